// File: doc/BRIEF.md
# Two-Wire Control Register Slave

This block is a slave on a two-wire serial management bus (SCL clock, SDA data). It gives a bus host read and write access to a small bank of byte-wide control registers, such as the per-output enable bits of a clock device. The contents of the bank appear continuously on a parallel output. Every register reloads a fixed default at reset, so the device behaves sensibly even if the host never touches the bus.

SCL and SDA are brought into the system clock domain through two-flop synchronizers. The system clock must run at least ten times faster than SCL. The block finds start and stop conditions from edges of the synchronized lines, samples data on SCL rising edges, and changes its own SDA drive only while SCL is low. It never drives SDA high. It only pulls the line low through an output enable, and the pad forms an open-drain driver from that enable.

The command byte chooses between two kinds of access. One reads or writes a single register at an offset. The other is a sequential block access that starts at register 0. A block write carries a byte count from the host, and on a block read the slave returns the count. A compatibility bit inside the bank removes the count phase, which makes block transfers look like plain sequential register transfers.

Top module: `smb_regif`

## Requirements
- R1: After reset every register holds its default value from the `REG_DEFAULTS` parameter (register k in bits 8k+7:8k), and `sda_oe` is low.
- R2: The slave acknowledges only address bytes whose upper seven bits equal 1101001, which gives D2h for a write and D3h for a read. Any other address gets no acknowledge, and `sda_oe` stays low until the next start. No register changes during such a transaction.
- R3: A command byte with bit 7 = 1 selects single-register access at the offset in bits 6:0. One data byte that follows in a write transaction is stored at that offset.
- R4: After a single-register command, a repeated start and the read address (D3h), the slave returns the register at that offset, MSB first.
- R5: A command byte of 00h selects block access. In a block write the slave acknowledges a count byte and then stores data bytes into registers 0, 1, 2 and so on in order. The count value does not limit how many bytes are stored.
- R6: A block read after the 00h command and the read address returns a count byte equal to the number of registers (8). It then returns registers 0, 1, 2 and so on in order.
- R7: When a block write is stopped after any complete data byte, the bytes already received stay written and the later registers keep their values.
- R8: A write to an offset at or beyond the register count is acknowledged and discarded. A read from such an offset returns 00h.
- R9: While bit 7 of register 7 is 1, block writes and block reads have no count byte, so the first data byte goes to or comes from register 0.
- R10: The slave acknowledges every byte it receives in a transaction addressed to it by pulling SDA low for the ninth clock. It raises `sda_oe` only while SCL is low.
- R11: When the host does not acknowledge a byte sent by the slave, the slave releases SDA and does not drive it again until the next start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 10x the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | When high, the pad pulls SDA low |
| regs_o | output | 64 | Register bank contents, register k in bits 8k+7:8k |

## Verification
A wrong bit counter or role state first shows as an acknowledge in the wrong bit slot, and the host sees that on the very next byte. A lost count phase or a wrong pointer shifts block data by one register. That shows on `regs_o` right after the write byte is acknowledged, or on SDA within the first read byte. A compatibility bit that is decoded wrongly shows up the same way, as a shift by one register in the first block transfer after the bit changes. A slave that does not release SDA after a host NACK holds the line low during the next SCL pulse.

// File: rtl/smb_pkg.sv
package smb_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_RXACK,
    ST_TX,
    ST_TXACK
  } smb_state_e;

  typedef enum logic [1:0] {
    RB_ADDR,
    RB_CMD,
    RB_CNT,
    RB_DATA
  } rx_role_e;

endpackage

// File: rtl/smb_sync.sv
module smb_sync #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic [W-1:0] q_d
);

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic [2:0] pipe;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe <= '1;
      else        pipe <= {pipe[1:0], d[i]};
    end
    assign q[i]   = pipe[1];
    assign q_d[i] = pipe[2];
  end

endmodule

// File: rtl/smb_regbank.sv
module smb_regbank #(
  parameter int                  NUM_REGS = 8,
  parameter logic [NUM_REGS*8-1:0] DEFAULTS = '0
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  we,
  input  logic [7:0]            waddr,
  input  logic [7:0]            wdata,
  input  logic [7:0]            raddr,
  output logic [7:0]            rdata,
  output logic [NUM_REGS*8-1:0] regs_flat
);

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    logic [7:0] regq;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       regq <= DEFAULTS[g*8 +: 8];
      else if (we && waddr == 8'(g))    regq <= wdata;
    end
    assign regs_flat[g*8 +: 8] = regq;
  end

  always_comb begin
    rdata = '0;
    for (int k = 0; k < NUM_REGS; k++) begin
      if (raddr == 8'(k)) rdata = regs_flat[k*8 +: 8];
    end
  end

  AST_OOR_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (we && waddr >= 8'(NUM_REGS)) |=> $stable(regs_flat)); // R8

endmodule

// File: rtl/smb_regif.sv
module smb_regif
  import smb_pkg::*;
#(
  parameter int                    NUM_REGS     = 8,
  parameter logic [6:0]            SLV_ADDR     = 7'h69,
  parameter logic [NUM_REGS*8-1:0] REG_DEFAULTS = 64'h15_5A_00_FF_C0_33_A5_01,
  parameter int                    CMPT_REG     = 7,
  parameter int                    CMPT_BIT     = 7
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  scl_i,
  input  logic                  sda_i,
  output logic                  sda_oe,
  output logic [NUM_REGS*8-1:0] regs_o
);

  localparam int         CMPT_POS = CMPT_REG * 8 + CMPT_BIT;
  localparam logic [7:0] CNT_BYTE = 8'(NUM_REGS);

  // reset: asynchronous assert, synchronous release
  logic rst_meta, rst_int;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_int  <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_int  <= rst_meta;
    end
  end

  // line synchronizers and bus events
  logic [1:0] lin_q, lin_qd;
  smb_sync #(.W(2)) i_sync (
    .clk(clk), .rst_n(rst_int), .d({scl_i, sda_i}), .q(lin_q), .q_d(lin_qd)
  );
  logic scl_s, sda_s, scl_p, sda_p;
  assign {scl_s, sda_s} = lin_q;
  assign {scl_p, sda_p} = lin_qd;

  logic start_ev, stop_ev, scl_rise, scl_fall;
  assign start_ev = scl_s && scl_p && sda_p && !sda_s;
  assign stop_ev  = scl_s && scl_p && !sda_p && sda_s;
  assign scl_rise = scl_s && !scl_p;
  assign scl_fall = !scl_s && scl_p;

  // state
  smb_state_e state, n_state;
  rx_role_e   role, n_role;
  logic [3:0] bitcnt, n_bitcnt;
  logic [7:0] shreg, n_shreg;
  logic [7:0] ptr, n_ptr;
  logic       oe_q, n_oe;
  logic       blk_q, n_blk;
  logic       rd_q, n_rd;
  logic       txcnt_q, n_txcnt;

  // bank interface
  logic       we;
  logic [7:0] rdata;
  logic       cmpt;
  logic [7:0] ptr_inc;
  logic [7:0] ld_byte;

  smb_regbank #(.NUM_REGS(NUM_REGS), .DEFAULTS(REG_DEFAULTS)) i_bank (
    .clk(clk), .rst_n(rst_int), .we(we), .waddr(ptr), .wdata(shreg),
    .raddr(ptr), .rdata(rdata), .regs_flat(regs_o)
  );

  assign cmpt    = regs_o[CMPT_POS];
  assign ptr_inc = (ptr == 8'hFF) ? ptr : ptr + 8'd1;
  assign ld_byte = txcnt_q ? CNT_BYTE : rdata;

  always_comb begin
    n_state  = state;
    n_role   = role;
    n_bitcnt = bitcnt;
    n_shreg  = shreg;
    n_ptr    = ptr;
    n_oe     = oe_q;
    n_blk    = blk_q;
    n_rd     = rd_q;
    n_txcnt  = txcnt_q;
    we       = 1'b0;
    if (start_ev) begin
      n_state  = ST_RX;
      n_role   = RB_ADDR;
      n_bitcnt = '0;
      n_oe     = 1'b0;
    end else if (stop_ev) begin
      n_state = ST_IDLE;
      n_oe    = 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: ;
        ST_RX: begin
          if (scl_rise) begin
            n_shreg  = {shreg[6:0], sda_s};
            n_bitcnt = bitcnt + 4'd1;
          end else if (scl_fall && bitcnt == 4'd8) begin
            n_bitcnt = '0;
            n_state  = ST_RXACK;
            n_oe     = 1'b1;
            n_rd     = 1'b0;
            unique case (role)
              RB_ADDR: begin
                if (shreg[7:1] != SLV_ADDR) begin
                  n_state = ST_IDLE;
                  n_oe    = 1'b0;
                end else if (shreg[0]) begin
                  n_rd    = 1'b1;
                  n_txcnt = blk_q && !cmpt;
                end else begin
                  n_role = RB_CMD;
                end
              end
              RB_CMD: begin
                n_blk  = !shreg[7];
                n_ptr  = shreg[7] ? {1'b0, shreg[6:0]} : 8'd0;
                n_role = (!shreg[7] && !cmpt) ? RB_CNT : RB_DATA;
              end
              RB_CNT:  n_role = RB_DATA;
              RB_DATA: begin
                we    = 1'b1;
                n_ptr = ptr_inc;
              end
              default: ;
            endcase
          end
        end
        ST_RXACK: begin
          if (scl_fall) begin
            n_bitcnt = '0;
            if (rd_q) begin
              n_state = ST_TX;
              n_shreg = ld_byte;
              n_oe    = !ld_byte[7];
              n_txcnt = 1'b0;
              if (!txcnt_q) n_ptr = ptr_inc;
            end else begin
              n_state = ST_RX;
              n_oe    = 1'b0;
            end
          end
        end
        ST_TX: begin
          if (scl_rise) begin
            n_bitcnt = bitcnt + 4'd1;
          end else if (scl_fall) begin
            if (bitcnt == 4'd8) begin
              n_oe    = 1'b0;
              n_state = ST_TXACK;
            end else begin
              n_shreg = {shreg[6:0], 1'b0};
              n_oe    = !shreg[6];
            end
          end
        end
        ST_TXACK: begin
          if (scl_rise && sda_s) begin
            n_state = ST_IDLE;
          end else if (scl_fall) begin
            n_bitcnt = '0;
            n_state  = ST_TX;
            n_shreg  = ld_byte;
            n_oe     = !ld_byte[7];
            n_txcnt  = 1'b0;
            if (!txcnt_q) n_ptr = ptr_inc;
          end
        end
        default: n_state = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_int) begin
    if (!rst_int) begin
      state   <= ST_IDLE;
      role    <= RB_ADDR;
      bitcnt  <= '0;
      shreg   <= '0;
      ptr     <= '0;
      oe_q    <= 1'b0;
      blk_q   <= 1'b0;
      rd_q    <= 1'b0;
      txcnt_q <= 1'b0;
    end else begin
      state   <= n_state;
      role    <= n_role;
      bitcnt  <= n_bitcnt;
      shreg   <= n_shreg;
      ptr     <= n_ptr;
      oe_q    <= n_oe;
      blk_q   <= n_blk;
      rd_q    <= n_rd;
      txcnt_q <= n_txcnt;
    end
  end

  assign sda_oe = oe_q;

  AST_OE_RISE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_int)
    $rose(sda_oe) |-> !scl_s); // R10
  AST_ACK_AFTER_BYTE: assert property (@(posedge clk) disable iff (!rst_int)
    (state == ST_RX && scl_fall && bitcnt == 4'd8 && role != RB_ADDR) |=> sda_oe); // R10
  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_int)
    (state == ST_IDLE) |-> !sda_oe); // R2
  AST_NACK_RELEASE: assert property (@(posedge clk) disable iff (!rst_int)
    (state == ST_TXACK && scl_rise && sda_s) |=> (!sda_oe && state == ST_IDLE)); // R11

endmodule

// File: tb/test_smb_regif.sv
module test_smb_regif;

  localparam int          Q   = 10;
  localparam logic [63:0] DEF = 64'h15_5A_00_FF_C0_33_A5_01;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        scl = 1'b1;
  logic        m_sda = 1'b1;
  logic        sda_oe;
  logic [63:0] regs_o;
  wire         sda_line = m_sda & ~sda_oe;

  int  nchk = 0;
  int  nerr = 0;
  bit  done = 1'b0;
  bit  nak_seen;
  logic [7:0] exp_r [8];
  logic [7:0] v [8];

  always #2 clk = ~clk;

  smb_regif #(.REG_DEFAULTS(DEF)) i_smb_regif (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
    .sda_oe(sda_oe), .regs_o(regs_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic chk_bank(input string req);
    for (int k = 0; k < 8; k++) chk(req, int'(regs_o[k*8 +: 8]), int'(exp_r[k]));
  endtask

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start;
    m_sda = 1'b1; hold(Q); scl = 1'b1; hold(Q);
    m_sda = 1'b0; hold(Q); scl = 1'b0; hold(Q);
  endtask

  task automatic bus_stop;
    m_sda = 1'b0; hold(Q); scl = 1'b1; hold(Q); m_sda = 1'b1; hold(Q);
  endtask

  task automatic bit_io(input logic b, output logic r);
    m_sda = b; hold(Q); scl = 1'b1; hold(Q);
    r = sda_line; hold(Q); scl = 1'b0; hold(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic r;
    for (int i = 7; i >= 0; i--) bit_io(b[i], r);
    bit_io(1'b1, r);
    ack = !r;
    if (r) nak_seen = 1'b1;
  endtask

  task automatic recv_byte(output logic [7:0] b, input logic last);
    logic r;
    for (int i = 7; i >= 0; i--) bit_io(1'b1, b[i]);
    bit_io(last, r);
  endtask

  task automatic wr_one(input logic [6:0] off, input logic [7:0] val);
    logic a;
    nak_seen = 1'b0;
    bus_start; send_byte(8'hD2, a); send_byte({1'b1, off}, a); send_byte(val, a); bus_stop;
    chk("R10 ack on byte write", int'(nak_seen), 0);
  endtask

  task automatic rd_one(input logic [6:0] off, output logic [7:0] val);
    logic a;
    nak_seen = 1'b0;
    bus_start; send_byte(8'hD2, a); send_byte({1'b1, off}, a);
    bus_start; send_byte(8'hD3, a); recv_byte(val, 1'b1); bus_stop;
    chk("R10 ack on byte read", int'(nak_seen), 0);
  endtask

  task automatic blk_wr(input int n, input bit with_cnt);
    logic a;
    nak_seen = 1'b0;
    bus_start; send_byte(8'hD2, a); send_byte(8'h00, a);
    if (with_cnt) send_byte(8'(n), a);
    for (int k = 0; k < n; k++) send_byte(v[k], a);
    bus_stop;
    chk("R10 ack on block write", int'(nak_seen), 0);
  endtask

  task automatic blk_rd(input bit with_cnt, input string req);
    logic a;
    logic [7:0] b;
    nak_seen = 1'b0;
    bus_start; send_byte(8'hD2, a); send_byte(8'h00, a);
    bus_start; send_byte(8'hD3, a);
    if (with_cnt) begin
      recv_byte(b, 1'b0);
      chk({req, " count byte"}, int'(b), 8);
    end
    for (int k = 0; k < 8; k++) begin
      recv_byte(b, k == 7);
      chk({req, " block data"}, int'(b), int'(exp_r[k]));
    end
    bus_stop;
    chk("R10 ack on block read", int'(nak_seen), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    logic a, r;
    logic [7:0] b;
    for (int k = 0; k < 8; k++) exp_r[k] = DEF[k*8 +: 8];
    hold(5); rst_n = 1'b1; hold(5);

    // R1: defaults after reset
    chk_bank("R1 reset default");
    chk("R1 sda released", int'(sda_oe), 0);

    // R2: foreign addresses get no ack and change nothing
    foreach (v[i]) v[i] = 8'h00;
    for (int t = 0; t < 4; t++) begin
      logic [7:0] adr;
      adr = (t == 0) ? 8'hD0 : (t == 1) ? 8'hD4 : (t == 2) ? 8'h52 : 8'hD6;
      bus_start; send_byte(adr, a);
      chk("R2 no ack for foreign address", int'(a), 0);
      send_byte(8'h83, a); send_byte(8'h3C, a);
      chk("R2 line released after foreign address", int'(sda_oe), 0);
      bus_stop;
    end
    chk_bank("R2 bank unchanged after foreign traffic");

    // R3: single-register write sweep
    for (int k = 0; k < 8; k++) begin
      b = 8'((k * 37 + 11) ^ 8'h5A);
      wr_one(7'(k), b);
      exp_r[k] = b;
      chk("R3 byte write target", int'(regs_o[k*8 +: 8]), int'(b));
    end
    chk_bank("R3 bank after byte writes");

    // R4: single-register read sweep
    for (int k = 0; k < 8; k++) begin
      rd_one(7'(k), b);
      chk("R4 byte read", int'(b), int'(exp_r[k]));
    end

    // R8: out-of-range offsets
    wr_one(7'd8, 8'hEE); wr_one(7'd9, 8'h11); wr_one(7'd127, 8'h77);
    chk_bank("R8 out-of-range write discarded");
    rd_one(7'd8, b);   chk("R8 out-of-range read", int'(b), 0);
    rd_one(7'd127, b); chk("R8 out-of-range read", int'(b), 0);

    // R5: full block write with count; bit 7 of last byte kept clear
    for (int k = 0; k < 8; k++) v[k] = 8'(8'hC3 ^ (k * 29)) & ((k == 7) ? 8'h7F : 8'hFF);
    blk_wr(8, 1'b1);
    for (int k = 0; k < 8; k++) exp_r[k] = v[k];
    chk_bank("R5 block write");

    // R6: block read with count
    blk_rd(1'b1, "R6");

    // R7: partial block write of three bytes
    for (int k = 0; k < 8; k++) v[k] = 8'(8'h90 + k * 3);
    blk_wr(3, 1'b1);
    for (int k = 0; k < 3; k++) exp_r[k] = v[k];
    chk_bank("R7 partial block write");

    // R11: host NACKs the first data byte, slave must stay off the line
    nak_seen = 1'b0;
    bus_start; send_byte(8'hD2, a); send_byte(8'h00, a);
    bus_start; send_byte(8'hD3, a);
    recv_byte(b, 1'b0); chk("R11 count before nack", int'(b), 8);
    recv_byte(b, 1'b1); chk("R11 first byte before nack", int'(b), int'(exp_r[0]));
    bit_io(1'b1, r);
    chk("R11 line released after nack", int'(r), 1);
    chk("R11 oe low after nack", int'(sda_oe), 0);
    bus_stop;

    // R9: set the compatibility bit, then block transfers without count
    b = exp_r[7] | 8'h80;
    wr_one(7'd7, b); exp_r[7] = b;
    for (int k = 0; k < 8; k++) v[k] = 8'(8'h21 + k * 17) | ((k == 7) ? 8'h80 : 8'h00);
    blk_wr(8, 1'b0);
    for (int k = 0; k < 8; k++) exp_r[k] = v[k];
    chk_bank("R9 block write without count");
    blk_rd(1'b0, "R9 no count");
    for (int k = 0; k < 8; k++) v[k] = 8'(8'h0E + k * 5) & ((k == 7) ? 8'h7F : 8'hFF);
    blk_wr(8, 1'b0);
    for (int k = 0; k < 8; k++) exp_r[k] = v[k];
    chk_bank("R9 block write clearing compatibility");
    blk_rd(1'b1, "R9 count restored");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

endmodule